// File: doc/BRIEF.md
# Write-Busy Status Read Responder

This block forms the byte returned on a read of a byte-wide nonvolatile memory, both while its internal programming cycle runs and after that cycle has finished. The write engine supplies a busy flag, the byte most recently written and a flag that is high while the array itself is being programmed. The array supplies the stored byte at the current address. A single-cycle or longer read-strobe marks the start of each new read access, that is, each output-enable or chip-select assertion.

While the engine is busy, the responder places two end-of-write status indications on the data bus. Bit 7 returns the inverse of bit 7 of the last written byte. Bit 6 changes level on every new read access. Software can poll either bit, starting at any point in the write cycle. When the engine goes idle, the responder passes the stored byte through unchanged. It also produces the enable for the external tri-state data drivers from the chip-select, output-enable and write-enable levels.

Top module: `busy_status_responder`

## Requirements
- R1: While `busy_i` is 1, each qualified read access (a rising edge of `rd_strobe_i` in a cycle where `cs_n_i`=0, `oe_n_i`=0 and `we_n_i`=1) inverts bit 6 of `rd_data_o`, and the new level is visible from the cycle after the strobe edge.
- R2: While `busy_i` is 0, read accesses do not advance the toggle state. When a later busy period begins, bit 6 resumes from the level it held at the end of the previous busy period.
- R3: While `busy_i` is 1, bit 7 of `rd_data_o` equals the inverse of bit 7 of `last_wr_i`.
- R4: While `busy_i` is 0, all eight bits of `rd_data_o` equal `arr_data_i`.
- R5: `bus_oe_o` is 1 only when `cs_n_i`=0, `oe_n_i`=0 and `we_n_i`=1. If either select input is 1, the drivers are off (high impedance).
- R6: A strobe held high for several cycles counts as one access. A strobe edge that arrives while `we_n_i`=0 or while a select input is 1 does not advance the toggle.
- R7: While `busy_i` is 1, bits 5..0 of `rd_data_o` equal `arr_data_i[5:0]`, or zero while `prog_i` is 1.
- R8: Synchronous active-low reset clears the toggle state to 0, so the first qualified busy read after reset returns 1 on bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Internal write cycle in progress |
| prog_i | input | 1 | Array is being programmed (low bits read as zero) |
| last_wr_i | input | 8 | Last byte written by the host |
| arr_data_i | input | 8 | Stored byte at the addressed location |
| rd_strobe_i | input | 1 | Goes high at the start of each read access |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| rd_data_o | output | 8 | Byte presented to the data bus |
| bus_oe_o | output | 1 | Tri-state driver enable for the data bus |

## Verification
The bench aims at the access-counting corners. A strobe held high over several cycles must count as one access; a design that toggled on the level would return a bit 6 with the wrong parity. Strobes that arrive during a write or while deselected must not count; counting them also shifts the parity. Idle periods between two busy periods must leave the toggle frozen; a free-running toggle would resume at the wrong level. Random mixes of busy, programming and select levels check the inverted bit 7, the zeroed low bits and the driver enable, which a swapped polarity or a missing select term would corrupt.

// File: rtl/bsr_pkg.sv
// Package: shared constants and helpers for the busy status responder.
// Assumes an 8-bit data bus by default; bit positions are polling contract.
package bsr_pkg;
    localparam int unsigned BSR_DATA_W   = 8;
    localparam int unsigned BSR_POLL_BIT = 7;
    localparam int unsigned BSR_TOG_BIT  = 6;

    // Output source chosen for one bus bit
    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_POLL   = 2'd1,
        SRC_TOGGLE = 2'd2,
        SRC_ZERO   = 2'd3
    } bit_src_e;

    // Single-bit mask at a given position
    function automatic logic [BSR_DATA_W-1:0] bit_mask(input int unsigned pos);
        logic [BSR_DATA_W-1:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/bsr_access_edge.sv
// Module: detects the start of a qualified read access.
// Assumes rd_strobe_i is synchronous to clk. A pulse is produced only on a
// rising strobe edge that lands while the bus is in a read state.
module bsr_access_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe_i,
    input  logic rd_qual_i,
    output logic edge_o
);
    logic strobe_q;

    // Remember previous strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= rd_strobe_i;
    end

    // Qualified rising edge
    always_comb begin
        edge_o = rd_strobe_i && !strobe_q && rd_qual_i;
    end

    // R6: a held strobe yields a single pulse
    p_edge_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/bsr_toggle.sv
// Module: toggle-bit state. Flips on each qualified access while busy,
// freezes while idle, clears on reset.
module bsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic access_i,
    output logic tog_o
);
    logic tog_q;

    // Advance toggle on accesses during a write cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                   tog_q <= 1'b0;
        else if (busy_i && access_i)  tog_q <= !tog_q;
    end

    assign tog_o = tog_q;

    // R1: access while busy inverts the toggle
    p_tog_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && access_i) |=> (tog_q != $past(tog_q)));
    // R2: toggle frozen while idle
    p_tog_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> $stable(tog_q));
    // R8: reset clears the toggle
    p_tog_reset_r8: assert property (@(posedge clk)
        !rst_n |=> !tog_q);
endmodule

// File: rtl/bsr_out_mux.sv
// Module: per-bit data source selection for the read bus.
// Assumes POLL_BIT != TOG_BIT, both below DATA_W.
module bsr_out_mux #(
    parameter int unsigned DATA_W   = bsr_pkg::BSR_DATA_W,
    parameter int unsigned POLL_BIT = bsr_pkg::BSR_POLL_BIT,
    parameter int unsigned TOG_BIT  = bsr_pkg::BSR_TOG_BIT
) (
    input  logic              busy_i,
    input  logic              prog_i,
    input  logic              tog_i,
    input  logic [DATA_W-1:0] last_wr_i,
    input  logic [DATA_W-1:0] arr_data_i,
    output logic [DATA_W-1:0] data_o
);
    import bsr_pkg::*;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        bit_src_e src;

        // Choose this bit's source from busy state and bit role
        always_comb begin
            if (!busy_i)                src = SRC_ARRAY;
            else if (i == POLL_BIT)     src = SRC_POLL;
            else if (i == TOG_BIT)      src = SRC_TOGGLE;
            else if (prog_i)            src = SRC_ZERO;
            else                        src = SRC_ARRAY;
        end

        // Drive the bit from the chosen source
        always_comb begin
            case (src)
                SRC_POLL:   data_o[i] = !last_wr_i[i];
                SRC_TOGGLE: data_o[i] = tog_i;
                SRC_ZERO:   data_o[i] = 1'b0;
                default:    data_o[i] = arr_data_i[i];
            endcase
        end
    end
endmodule

// File: rtl/busy_status_responder.sv
// Module: top of the write-busy status read responder.
// Merges data-polling (inverted bit) and toggle-bit status onto the read
// bus while busy, passes stored data when idle, and gates the bus drivers.
// Assumes all inputs are synchronous to clk.
module busy_status_responder #(
    parameter int unsigned DATA_W   = bsr_pkg::BSR_DATA_W,
    parameter int unsigned POLL_BIT = bsr_pkg::BSR_POLL_BIT,
    parameter int unsigned TOG_BIT  = bsr_pkg::BSR_TOG_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              prog_i,
    input  logic [DATA_W-1:0] last_wr_i,
    input  logic [DATA_W-1:0] arr_data_i,
    input  logic              rd_strobe_i,
    input  logic              cs_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              bus_oe_o
);
    localparam logic [DATA_W-1:0] STATUS_MASK =
        bsr_pkg::bit_mask(POLL_BIT) | bsr_pkg::bit_mask(TOG_BIT);

    logic rd_qual;
    logic access;
    logic tog;

    // Read state: selected, output enabled, not writing
    always_comb begin
        rd_qual  = !cs_n_i && !oe_n_i && we_n_i;
        bus_oe_o = rd_qual;
    end

    bsr_access_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_strobe_i (rd_strobe_i),
        .rd_qual_i   (rd_qual),
        .edge_o      (access)
    );

    bsr_toggle u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (busy_i),
        .access_i (access),
        .tog_o    (tog)
    );

    bsr_out_mux #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_mux (
        .busy_i     (busy_i),
        .prog_i     (prog_i),
        .tog_i      (tog),
        .last_wr_i  (last_wr_i),
        .arr_data_i (arr_data_i),
        .data_o     (rd_data_o)
    );

    // R3: polling bit inverted from last written byte
    p_poll_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (rd_data_o[POLL_BIT] == !last_wr_i[POLL_BIT]));
    // R4: idle read passes stored data
    p_idle_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (rd_data_o == arr_data_i));
    // R5: drivers off when deselected or writing
    p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i || oe_n_i || !we_n_i) |-> !bus_oe_o);
    // R7: low bits zero during array programming
    p_prog_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && prog_i) |-> ((rd_data_o & ~STATUS_MASK) == '0));
    // R1: bus toggle bit follows a qualified busy access
    p_bus_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_qual && rd_strobe_i && !$past(rd_strobe_i) && $past(rst_n))
        |=> (busy_i -> (rd_data_o[TOG_BIT] != $past(rd_data_o[TOG_BIT]))));
endmodule

// File: tb/busy_status_responder_bench.sv
`timescale 1ns/1ps
module busy_status_responder_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       busy, prog, strobe, cs_n, oe_n, we_n;
    logic [7:0] last_wr, arr;
    logic [7:0] rd_data;
    logic       bus_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic exp_tog = 1'b0;

    always #2.5 clk = ~clk;

    busy_status_responder u_busy_status_responder (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy),
        .prog_i      (prog),
        .last_wr_i   (last_wr),
        .arr_data_i  (arr),
        .rd_strobe_i (strobe),
        .cs_n_i      (cs_n),
        .oe_n_i      (oe_n),
        .we_n_i      (we_n),
        .rd_data_o   (rd_data),
        .bus_oe_o    (bus_oe)
    );

    function automatic logic [7:0] exp_data(input logic b, input logic p,
                                            input logic t, input logic [7:0] lw,
                                            input logic [7:0] a);
        if (!b) return a;
        return {~lw[7], t, (p ? 6'd0 : a[5:0])};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, hold strobe for 'hold' cycles (0 = none)
    task automatic access(input logic b, input logic p, input logic [7:0] lw,
                          input logic [7:0] a, input logic c, input logic o,
                          input logic w, input int hold);
        logic [7:0] e;
        @(negedge clk);
        busy = b; prog = p; last_wr = lw; arr = a;
        cs_n = c; oe_n = o; we_n = w;
        strobe = (hold > 0);
        if (hold > 0 && b && !c && !o && w) exp_tog = ~exp_tog;
        for (int k = 0; k < ((hold > 0) ? hold : 1); k++) @(negedge clk);
        e = exp_data(b, p, exp_tog, lw, a);
        chk("R5 bus_oe", {7'd0, bus_oe}, {7'd0, (!c && !o && w)});
        if (b) begin
            chk("R3 poll bit7", {7'd0, rd_data[7]}, {7'd0, e[7]});
            chk("R1/R2/R6/R8 toggle bit6", {7'd0, rd_data[6]}, {7'd0, e[6]});
            chk("R7 low bits", {2'd0, rd_data[5:0]}, {2'd0, e[5:0]});
        end else begin
            chk("R4 idle data", rd_data, e);
        end
        strobe = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; busy = 1'b1; prog = 1'b0; strobe = 1'b0;
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; last_wr = 8'h80; arr = 8'h15;
        repeat (3) @(negedge clk);
        // R8: toggle state zero under reset
        chk("R8 reset toggle", {7'd0, rd_data[6]}, 8'd0);
        chk("R3 reset poll", {7'd0, rd_data[7]}, 8'd0);
        @(negedge clk); rst_n = 1'b1;

        // R4 idle pass-through, R5 deselect
        access(1'b0, 1'b0, 8'h00, 8'hA5, 1'b0, 1'b0, 1'b1, 1);
        access(1'b0, 1'b0, 8'h00, 8'h3C, 1'b1, 1'b0, 1'b1, 0);
        access(1'b0, 1'b0, 8'h00, 8'h3C, 1'b0, 1'b1, 1'b1, 0);
        // R8: first busy access after reset gives 1
        access(1'b1, 1'b0, 8'h7F, 8'h2A, 1'b0, 1'b0, 1'b1, 1);
        chk("R8 first toggle", {7'd0, rd_data[6]}, 8'd1);
        // R6: held strobe counts once
        access(1'b1, 1'b0, 8'h7F, 8'h2A, 1'b0, 1'b0, 1'b1, 5);
        // R6: strobe during write or deselect ignored
        access(1'b1, 1'b0, 8'hFF, 8'h11, 1'b0, 1'b1, 1'b0, 1);
        access(1'b1, 1'b0, 8'hFF, 8'h11, 1'b1, 1'b0, 1'b1, 1);
        access(1'b1, 1'b0, 8'hFF, 8'h11, 1'b0, 1'b0, 1'b1, 0);
        // R2: idle strobes do not move the toggle
        access(1'b0, 1'b0, 8'h00, 8'h55, 1'b0, 1'b0, 1'b1, 1);
        access(1'b0, 1'b0, 8'h00, 8'h55, 1'b0, 1'b0, 1'b1, 1);
        access(1'b0, 1'b0, 8'h00, 8'h55, 1'b0, 1'b0, 1'b1, 1);
        access(1'b1, 1'b0, 8'h00, 8'h55, 1'b0, 1'b0, 1'b1, 0);
        // R7: programming zeroes low bits
        access(1'b1, 1'b1, 8'h01, 8'hFF, 1'b0, 1'b0, 1'b1, 1);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [9:0] r;
            r = 10'($urandom);
            access(r[0] | r[1], r[2], 8'($urandom), 8'($urandom),
                   r[3] & r[4], r[5] & r[6], ~(r[7] & r[8]),
                   r[9] ? int'($urandom_range(1, 3)) : 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule